// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox

This block lets two processors exchange 32-bit messages through sixteen independent first-in, first-out queues. Each queue holds up to four messages. One processor writes a message to a queue's message port and the other reads it back from the same address. The block is reached over a simple single-cycle register bus with an address, a write strobe, write data, a read strobe and read data.

The register map has three banks, each one word per queue. The first bank is the message ports: a write pushes and a read pops. The second bank reports whether each queue is full. The third bank reports how many messages each queue holds. A per-queue non-empty vector lets a consumer poll without bus traffic. A per-queue sticky overflow vector records any message that arrived when its queue had no room. Software checks the count before popping, because a read of an empty queue returns a stale word and not a new message.

Top module: `ipc_mailbox`

## Requirements
- R1: A write to byte offset 0x40 + 4*q (q = 0..15) appends the write data to queue q when that queue holds fewer than 4 messages, and the count of q increases by one.
- R2: A read of offset 0x40 + 4*q on a non-empty queue returns the oldest message, in write order. The data appears on `bus_rdata` one clock after the read strobe, and the message leaves the queue on that same edge.
- R3: Offset 0x80 + 4*q reads 1 in bit 0 (all other bits 0) when queue q holds 4 messages, and 0 otherwise.
- R4: Offset 0xC0 + 4*q reads the number of messages in queue q, 0 to 4, in the low bits.
- R5: A read of the message port of an empty queue leaves the count and contents unchanged. It returns the last message that left that queue, or 0 if no message has left it since reset.
- R6: A write to a full queue is dropped and its count stays at 4. Bit q of `q_overflow` goes to 1 and stays at 1 until reset.
- R7: Reads of the full and count banks have no side effects. Writes to those banks change nothing.
- R8: An access whose offset is below 0x40, is not a multiple of 4, or is at or above 0x100 reads as 0 and changes no state.
- R9: Bit q of `q_nonempty` is 1 exactly when queue q holds at least one message.
- R10: While `rst` is high at a clock edge, every queue is emptied, every overflow bit and all stored words are cleared, and `bus_rdata` becomes 0.
- R11: When `bus_wr` and `bus_rd` are both high in one cycle, only the write is performed. The read is dropped and `bus_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| q_nonempty | output | 16 | Per-queue non-empty flags |
| q_overflow | output | 16 | Per-queue sticky overflow flags |

## Verification
The hardest case to reach from the ports is a read of an empty queue whose ring has already wrapped. The stale word returned must then be the last message popped, not just any slot of the ring. The stimulus fills one queue to capacity, attempts a fifth write, drains it, and then reads again. Long runs of biased random traffic on four queues keep rings wrapping past their full and empty boundaries. A behavioural model built from per-queue lists and a last-popped word tracks every cycle. Unaligned and out-of-bank accesses and combined read-and-write strobes are mixed into the same traffic.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // Bank field of the offset, located just above the queue index bits.
    typedef enum logic [1:0] {
        BANK_NONE = 2'b00,
        BANK_MSG  = 2'b01,
        BANK_FULL = 2'b10,
        BANK_CNT  = 2'b11
    } bank_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int NUM_Q  = 16,
    parameter int ADDR_W = 8,
    localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bank_e             bank,
    output logic [QW-1:0]     qidx,
    output logic              rd_hit,
    output logic [NUM_Q-1:0]  push,
    output logic [NUM_Q-1:0]  pop
);
    localparam int BANK_LSB = 2 + QW;
    localparam int TOP_LSB  = BANK_LSB + 2;

    logic in_range;
    logic hi_zero;
    logic aligned;
    logic mapped;

    generate
        if (NUM_Q == (1 << QW)) begin : g_pow2
            assign in_range = 1'b1;
        end else begin : g_partial
            assign in_range = ({1'b0, qidx} < (QW+1)'(NUM_Q));
        end
    endgenerate

    always_comb begin
        qidx    = addr[BANK_LSB-1:2];
        aligned = (addr[1:0] == 2'b00);
        hi_zero = ((addr >> TOP_LSB) == '0);
        mapped  = aligned && hi_zero && in_range;
        bank    = mapped ? bank_e'(addr[BANK_LSB+1:BANK_LSB]) : BANK_NONE;
        rd_hit  = rd && !wr;
        push    = '0;
        pop     = '0;
        if (bank == BANK_MSG) begin
            if (wr) begin
                push[qidx] = 1'b1;
            end else if (rd) begin
                pop[qidx] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mbx_queue.sv
module mbx_queue #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              nonempty,
    output logic              overflow
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] slot;
        logic [PW-1:0]                rd_ptr;
        logic [PW-1:0]                wr_ptr;
        logic [CW-1:0]                count;
        logic                         ovf;
    } qstate_t;

    qstate_t st_d, st_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            if (st_q.count == CW'(DEPTH)) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.slot[st_q.wr_ptr] = wdata;
                st_d.wr_ptr            = ptr_inc(st_q.wr_ptr);
                st_d.count             = st_q.count + CW'(1);
            end
        end else if (pop && (st_q.count != '0)) begin
            st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            st_d.count  = st_q.count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // An empty ring's previous slot holds the last message that left it.
    assign head     = (st_q.count != '0) ? st_q.slot[st_q.rd_ptr]
                                         : st_q.slot[ptr_dec(st_q.rd_ptr)];
    assign count    = st_q.count;
    assign full     = (st_q.count == CW'(DEPTH));
    assign nonempty = (st_q.count != '0);
    assign overflow = st_q.ovf;

    p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_push_grows_r1: assert property (@(posedge clk) disable iff (rst)
        push && !full |=> count == $past(count) + CW'(1));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        push && full |=> full && overflow);

    p_sticky_ovf_r6: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
        pop && !push && !nonempty |=> !nonempty && $stable(head));

    p_single_op_r11: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter int NUM_Q  = 16,
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_Q-1:0]  q_nonempty,
    output logic [NUM_Q-1:0]  q_overflow
);
    localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    bank_e              bank;
    logic [QW-1:0]      qidx;
    logic               rd_hit;
    logic [NUM_Q-1:0]   push;
    logic [NUM_Q-1:0]   pop;
    logic [DATA_W-1:0]  head  [NUM_Q];
    logic [CW-1:0]      cnt   [NUM_Q];
    logic [NUM_Q-1:0]   full;

    mbx_decode #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_decode (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .bank   (bank),
        .qidx   (qidx),
        .rd_hit (rd_hit),
        .push   (push),
        .pop    (pop)
    );

    generate
        for (genvar i = 0; i < NUM_Q; i++) begin : g_q
            mbx_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
                .clk      (clk),
                .rst      (rst),
                .push     (push[i]),
                .pop      (pop[i]),
                .wdata    (bus_wdata),
                .head     (head[i]),
                .count    (cnt[i]),
                .full     (full[i]),
                .nonempty (q_nonempty[i]),
                .overflow (q_overflow[i])
            );

            p_nonempty_cnt_r9: assert property (@(posedge clk) disable iff (rst)
                q_nonempty[i] == (cnt[i] != '0));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (rd_hit) begin
            case (bank)
                BANK_MSG:  st_d.rdata = head[qidx];
                BANK_FULL: st_d.rdata = DATA_W'(full[qidx]);
                BANK_CNT:  st_d.rdata = DATA_W'(cnt[qidx]);
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
        rd_hit && bank == BANK_NONE |=> bus_rdata == '0);

    p_hold_on_both_r11: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_wr |=> $stable(bus_rdata));

    p_status_no_pop_r7: assert property (@(posedge clk) disable iff (rst)
        (bank == BANK_FULL || bank == BANK_CNT) |-> pop == '0 && push == '0);
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
    localparam int NQ = 16;
    localparam int DP = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic        wr;
    logic        rd;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [15:0] nonempty;
    logic [15:0] ovf_o;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    logic [31:0] mq [NQ][$];
    logic [31:0] last_out [NQ];
    bit          ovf_m [NQ];
    logic [31:0] exp_rd;

    always #5 clk = ~clk;

    ipc_mailbox u_dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata),
        .q_nonempty(nonempty), .q_overflow(ovf_o)
    );

    task automatic model_reset();
        for (int i = 0; i < NQ; i++) begin
            mq[i].delete();
            last_out[i] = '0;
            ovf_m[i]    = 1'b0;
        end
        exp_rd = '0;
    endtask

    // Behavioural model: bank in offset bits 7:6, queue in bits 5:2.
    task automatic model_step();
        int  q    = int'(addr[5:2]);
        int  bank = int'(addr[7:6]);
        bit  ok   = (addr[1:0] == 2'b00);
        if (wr) begin
            if (ok && bank == 1) begin
                if (mq[q].size() < DP) mq[q].push_back(wdata);
                else ovf_m[q] = 1'b1;
            end
        end else if (rd) begin
            if (!ok || bank == 0) exp_rd = '0;
            else if (bank == 1) begin
                if (mq[q].size() > 0) begin
                    exp_rd      = mq[q].pop_front();
                    last_out[q] = exp_rd;
                end else begin
                    exp_rd = last_out[q];
                end
            end else if (bank == 2) exp_rd = (mq[q].size() == DP) ? 32'd1 : 32'd0;
            else exp_rd = 32'(mq[q].size());
        end
    endtask

    task automatic compare(string tag);
        logic [15:0] en, eo;
        for (int i = 0; i < NQ; i++) begin
            en[i] = (mq[i].size() != 0);
            eo[i] = ovf_m[i];
        end
        compared++;
        if (rdata !== exp_rd) begin
            mismatched++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, exp_rd);
        end
        compared++;
        if (nonempty !== en) begin
            mismatched++;
            $display("FAIL R9 nonempty actual=%h expected=%h", nonempty, en);
        end
        compared++;
        if (ovf_o !== eo) begin
            mismatched++;
            $display("FAIL R6 overflow actual=%h expected=%h", ovf_o, eo);
        end
    endtask

    task automatic cycle(input logic [7:0] a, input logic w, input logic r,
                         input logic [31:0] d, input string tag);
        @(negedge clk);
        addr = a; wr = w; rd = r; wdata = d;
        @(posedge clk);
        if (rst) model_reset();
        else model_step();
        #1;
        compare(tag);
    endtask

    task automatic expect_val(input logic [31:0] e, input string tag);
        compared++;
        if (rdata !== e) begin
            mismatched++;
            $display("FAIL %s literal actual=%h expected=%h", tag, rdata, e);
        end
    endtask

    task automatic push(input int q, input logic [31:0] d, input string tag);
        cycle(8'(8'h40 + 4*q), 1'b1, 1'b0, d, tag);
    endtask
    task automatic pop(input int q, input string tag);
        cycle(8'(8'h40 + 4*q), 1'b0, 1'b1, 32'h0, tag);
    endtask
    task automatic rd_full(input int q, input string tag);
        cycle(8'(8'h80 + 4*q), 1'b0, 1'b1, 32'h0, tag);
    endtask
    task automatic rd_cnt(input int q, input string tag);
        cycle(8'(8'hC0 + 4*q), 1'b0, 1'b1, 32'h0, tag);
    endtask
    task automatic idle(input string tag);
        cycle(8'h00, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
        model_reset();
        idle("R10");
        idle("R10");
        rst = 1'b0;
        // R10: reset state
        rd_cnt(0, "R10");       expect_val(32'd0, "R10");
        // R5: empty read after reset yields 0
        pop(3, "R5");           expect_val(32'd0, "R5");
        rd_cnt(3, "R5");        expect_val(32'd0, "R5");
        // R1, R4, R2: three messages in order
        push(0, 32'h1111_0001, "R1");
        push(0, 32'h1111_0002, "R1");
        push(0, 32'h1111_0003, "R1");
        rd_cnt(0, "R4");        expect_val(32'd3, "R4");
        rd_full(0, "R3");       expect_val(32'd0, "R3");
        pop(0, "R2");           expect_val(32'h1111_0001, "R2");
        pop(0, "R2");           expect_val(32'h1111_0002, "R2");
        pop(0, "R2");           expect_val(32'h1111_0003, "R2");
        pop(0, "R5");           expect_val(32'h1111_0003, "R5");
        // R3, R6: fill queue 5, then overflow
        for (int i = 0; i < DP; i++) push(5, 32'hA5A5_0000 + 32'(i), "R1");
        rd_full(5, "R3");       expect_val(32'd1, "R3");
        push(5, 32'hDEAD_BEEF, "R6");
        rd_cnt(5, "R6");        expect_val(32'd4, "R6");
        for (int i = 0; i < DP; i++) begin
            pop(5, "R2");       expect_val(32'hA5A5_0000 + 32'(i), "R2");
        end
        pop(5, "R5");           expect_val(32'hA5A5_0003, "R5");
        rd_cnt(5, "R5");        expect_val(32'd0, "R5");
        idle("R6");
        // R7: status banks ignore writes and reads do not pop
        push(2, 32'h2222_2222, "R1");
        cycle(8'h88, 1'b1, 1'b0, 32'hFFFF_FFFF, "R7");
        cycle(8'hC8, 1'b1, 1'b0, 32'h0000_0003, "R7");
        rd_cnt(2, "R7");        expect_val(32'd1, "R7");
        rd_cnt(2, "R7");        expect_val(32'd1, "R7");
        rd_full(2, "R7");       expect_val(32'd0, "R7");
        // R8: unmapped and unaligned offsets
        cycle(8'h04, 1'b1, 1'b0, 32'h5555_5555, "R8");
        cycle(8'h49, 1'b1, 1'b0, 32'h6666_6666, "R8");
        cycle(8'h49, 1'b0, 1'b1, 32'h0, "R8");        expect_val(32'd0, "R8");
        cycle(8'h04, 1'b0, 1'b1, 32'h0, "R8");        expect_val(32'd0, "R8");
        rd_cnt(2, "R8");        expect_val(32'd1, "R8");
        pop(2, "R8");           expect_val(32'h2222_2222, "R8");
        // R11: read and write together
        rd_cnt(2, "R11");       expect_val(32'd0, "R11");
        cycle(8'h5C, 1'b1, 1'b1, 32'h7777_0007, "R11");  expect_val(32'd0, "R11");
        rd_cnt(7, "R11");       expect_val(32'd1, "R11");
        // Random traffic biased onto four queues
        for (int n = 0; n < 4000; n++) begin
            int q = $urandom_range(0, 3);
            int k = $urandom_range(0, 11);
            if (k < 4)       push(q, $urandom, "R1");
            else if (k < 7)  pop(q, "R2");
            else if (k == 7) rd_full(q, "R3");
            else if (k == 8) rd_cnt(q, "R4");
            else if (k == 9) cycle(8'($urandom), 1'($urandom), 1'($urandom), $urandom, "R8");
            else if (k == 10) cycle(8'(8'h40 + 4*q), 1'b1, 1'b1, $urandom, "R11");
            else idle("R9");
        end
        // R10: reset clears queues, overflow and stale words
        rst = 1'b1;
        idle("R10");
        rst = 1'b0;
        compared++;
        if (ovf_o !== 16'h0 || nonempty !== 16'h0) begin
            mismatched++;
            $display("FAIL R10 flags actual=%h/%h expected=0/0", ovf_o, nonempty);
        end
        pop(5, "R10");          expect_val(32'd0, "R10");
        pop(0, "R10");          expect_val(32'd0, "R10");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule